// File: doc/BRIEF.md
# Two-Rate Quasi-Cyclic LDPC Encoder

This block turns a stream of information blocks into a systematic codeword of a quasi-cyclic LDPC code. Each codeword is 16 circulant blocks of `Z` bits. At the low rate (1/2), 8 information blocks are followed by 8 parity blocks. At the high rate (3/4), 12 information blocks are followed by 4 parity blocks. One block moves per beat on both the input and the output. With `Z` = 32 at a 312.5 MHz clock, the output carries 10 Gbit/s.

Parity comes from a bank of shift-register adder-accumulator cells, one per parity block. Both rates use the same bank. As an information block is accepted, each cell XORs in the generator row for that block once for each set bit, rotating the row by one position between bits. The cells hold the parity until the last information block has gone in. The parity blocks then leave the block in ascending order.

Both sides use valid/ready. A beat moves when valid and ready are high at the same clock edge. While information blocks flow, the block is a pass-through: `in_ready` follows `out_ready` combinationally and `out_valid` follows `in_valid`. While parity flows, `in_ready` is low and `out_valid` is high. A parity beat held back by a low `out_ready` keeps its data until it is taken.

Top module: `qc_ldpc_enc`

## Requirements
- R1: After reset the block waits for the first information block of a codeword. With `in_valid` low, `out_valid` is low and `in_ready` equals `out_ready`.
- R2: While information blocks are being taken, each accepted `in_data` appears unchanged on `out_data` in the same cycle, and `in_ready` equals `out_ready`.
- R3: With rate select 0 a codeword is 8 information beats then 8 parity beats. With rate select 1 it is 12 information beats then 4 parity beats.
- R4: Parity block j is the XOR, over information blocks i and set bits k of block i, of generator row (i,j) rotated by k. The rotated row's bit c is bit (c-k) mod Z of the row. Bit k of any block is bit k of the bus.
- R5: Generator row (i,j) is the low Z bits of ((i+1)·0x9E3779B1 XOR (j+1)·0x85EBCA6B XOR (0xC2B2AE35 if the rate is 3/4, else 0)) OR 1, computed modulo 2^32. Every codeword therefore satisfies the parity-check relation built from these rows.
- R6: `rate_sel` is sampled only on the first information beat of a codeword. Changes at any later beat of that codeword have no effect on its length or parity.
- R7: The accumulators restart on every codeword. Parity never depends on an earlier codeword.
- R8: While a parity beat is offered and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R9: `out_last` is high on the final parity beat of each codeword and on no other output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 1 | 0 = rate 1/2, 1 = rate 3/4; taken at codeword start |
| in_valid | input | 1 | Information block offered |
| in_ready | output | 1 | Information block accepted this cycle |
| in_data | input | Z | Information block, bit k = block bit k |
| out_valid | output | 1 | Codeword block offered |
| out_ready | input | 1 | Downstream accepts block |
| out_data | output | Z | Codeword block |
| out_last | output | 1 | Final block of the codeword |

## Verification
Two situations are hard to reach from the ports. The first is a stall that lands inside the parity phase while information beats were also gappy. The bench throttles both `in_valid` and `out_ready` at random, so stalls fall on every beat position, including the boundary into and out of parity. The second is a rate change in the middle of a codeword. The bench drives a random `rate_sel` on every beat after the first and checks that length and parity still follow the rate taken at the start. Back-to-back codewords with different rates, plus directed all-zero, single-bit and all-one blocks, check that the accumulators restart and that each rotation lands on the right bit.

// File: rtl/qcenc_pkg.sv
package qcenc_pkg;
  localparam int unsigned BLKS    = 16;
  localparam int unsigned INFO_LO = 8;
  localparam int unsigned INFO_HI = 12;

  typedef enum logic {PH_INFO, PH_PAR} phase_e;

  // First row of generator circulant (info block i, parity block j); bit 0 forced set
  function automatic logic [31:0] first_row(logic hi, logic [31:0] i, logic [31:0] j);
    logic [31:0] a, b;
    a = (i + 32'd1) * 32'h9E3779B1;
    b = (j + 32'd1) * 32'h85EBCA6B;
    return (a ^ b ^ (hi ? 32'hC2B2AE35 : 32'h0)) | 32'h1;
  endfunction
endpackage

// File: rtl/sraa_cell.sv
module sraa_cell #(
  parameter int unsigned Z = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         restart,
  input  logic [Z-1:0] bits,
  input  logic [Z-1:0] row,
  output logic [Z-1:0] acc
);
  logic [Z-1:0] contrib;
  logic [Z-1:0] rot;

  // Unrolled shift-register adder-accumulator: add row when bit set, then rotate
  always_comb begin
    rot     = row;
    contrib = '0;
    for (int k = 0; k < int'(Z); k++) begin
      if (bits[k]) contrib = contrib ^ rot;
      rot = {rot[Z-2:0], rot[Z-1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (load)    acc <= restart ? contrib : (acc ^ contrib);
  end

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(acc));
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (load && restart) |=> (acc == $past(contrib)));
endmodule

// File: rtl/enc_seq.sv
module enc_seq
  import qcenc_pkg::*;
#(
  parameter int unsigned NB  = BLKS,
  parameter int unsigned KLO = INFO_LO,
  parameter int unsigned KHI = INFO_HI,
  localparam int unsigned CW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rate_sel,
  input  logic          in_valid,
  input  logic          out_ready,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          rate_eff,
  output logic          first_beat,
  output logic          info_fire,
  output logic          in_ready,
  output logic          last
);
  localparam logic [CW-1:0] KLO_C = CW'(KLO);
  localparam logic [CW-1:0] KHI_C = CW'(KHI);
  localparam logic [CW:0]   NB_C  = (CW+1)'(NB);

  logic          rate_q;
  logic [CW-1:0] n_info;
  logic [CW-1:0] n_par;

  always_comb begin
    rate_eff   = (phase == PH_INFO && cnt == '0) ? rate_sel : rate_q;
    n_info     = rate_eff ? KHI_C : KLO_C;
    n_par      = CW'(NB_C - {1'b0, n_info});
    first_beat = (cnt == '0);
    in_ready   = (phase == PH_INFO) && out_ready;
    info_fire  = in_ready && in_valid;
    last       = (phase == PH_PAR) && (cnt == n_par - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_INFO;
      cnt    <= '0;
      rate_q <= 1'b0;
    end else if (info_fire) begin
      if (cnt == '0) rate_q <= rate_sel;
      if (cnt == n_info - 1'b1) begin
        phase <= PH_PAR;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (phase == PH_PAR && out_ready) begin
      if (last) begin
        phase <= PH_INFO;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r6_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(info_fire && first_beat) |=> $stable(rate_q));
  a_r3_info_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INFO) |-> (cnt < n_info));
  a_r3_par_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAR) |-> (cnt < n_par));
  a_r9_last_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (last && out_ready) |=> (phase == PH_INFO && cnt == '0));
endmodule

// File: rtl/qc_ldpc_enc.sv
module qc_ldpc_enc
  import qcenc_pkg::*;
#(
  parameter int unsigned Z = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rate_sel,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [Z-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [Z-1:0] out_data,
  output logic         out_last
);
  localparam int unsigned MAXP = BLKS - INFO_LO;
  localparam int unsigned CW   = $clog2(BLKS);
  localparam int unsigned PW   = $clog2(MAXP);

  phase_e          phase;
  logic [CW-1:0]   cnt;
  logic            rate_eff;
  logic            first_beat;
  logic            info_fire;
  logic [Z-1:0]    par_acc [MAXP];

  enc_seq #(.NB(BLKS), .KLO(INFO_LO), .KHI(INFO_HI)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .phase     (phase),
    .cnt       (cnt),
    .rate_eff  (rate_eff),
    .first_beat(first_beat),
    .info_fire (info_fire),
    .in_ready  (in_ready),
    .last      (out_last)
  );

  for (genvar j = 0; j < int'(MAXP); j++) begin : g_cell
    logic [31:0] raw;
    assign raw = first_row(rate_eff, 32'(cnt), 32'(j));
    sraa_cell #(.Z(Z)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (info_fire),
      .restart(first_beat),
      .bits   (in_data),
      .row    (raw[Z-1:0]),
      .acc    (par_acc[j])
    );
  end

  always_comb begin
    if (phase == PH_PAR) begin
      out_valid = 1'b1;
      out_data  = par_acc[cnt[PW-1:0]];
    end else begin
      out_valid = in_valid;
      out_data  = in_data;
    end
  end

  a_r8_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAR && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r9_last_in_par: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (phase == PH_PAR && out_valid));
endmodule

// File: tb/sim_qc_ldpc_enc.sv
module sim_qc_ldpc_enc;
  localparam int Z = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic rate_sel, in_valid, in_ready, out_valid, out_ready, out_last;
  logic [Z-1:0] in_data, out_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] u [16];
  logic [Z-1:0] got [16];
  logic lastf [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  qc_ldpc_enc #(.Z(Z)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  function automatic logic [31:0] grow(logic hi, int i, int j);
    logic [31:0] a, b;
    a = 32'(i + 1) * 32'h9E3779B1;
    b = 32'(j + 1) * 32'h85EBCA6B;
    return (a ^ b ^ (hi ? 32'hC2B2AE35 : 32'h0)) | 32'h1;
  endfunction

  // Syndrome of check row (j, c): parity bit XOR all information contributions
  function automatic logic syndrome(logic hi, int j, int c, logic pbit);
    logic s;
    logic [31:0] r;
    s = pbit;
    for (int i = 0; i < (hi ? 12 : 8); i++) begin
      r = grow(hi, i, j);
      for (int k = 0; k < Z; k++)
        if (u[i][k] && r[(c - k + Z) % Z]) s = ~s;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_cw(input logic r, input bit stress);
    int k, sent, rcv, guard;
    logic pstall;
    logic [Z-1:0] pdata;
    logic s_ok;
    k = r ? 12 : 8;
    sent = 0; rcv = 0; guard = 0; pstall = 1'b0; pdata = '0;
    while (rcv < 16 && guard < 400) begin
      @(negedge clk);
      out_ready = stress ? ($urandom % 4 != 0) : 1'b1;
      in_valid  = (sent < k) ? (stress ? ($urandom % 3 != 0) : 1'b1) : 1'b0;
      in_data   = u[sent % 16][Z-1:0];
      rate_sel  = (sent == 0) ? r : 1'($urandom % 2);  // R6 mid-codeword noise
      #1;
      if (pstall)
        check(out_valid && out_data == pdata, "R8 stall hold", 32'(out_data), 32'(pdata));
      pstall = 1'b0;
      if (sent < k)
        check(in_ready == out_ready, "R2 ready follows", 32'(in_ready), 32'(out_ready));
      if (out_valid && out_ready && rcv < 16) begin
        got[rcv] = out_data;
        lastf[rcv] = out_last;
        rcv++;
      end
      if (in_valid && in_ready) sent++;
      if (out_valid && !out_ready && rcv >= k) begin
        pstall = 1'b1;
        pdata = out_data;
      end
      guard++;
    end
    check(rcv == 16 && sent == k, "R3 beat count", 32'(sent), 32'(k));
    for (int i = 0; i < k; i++)
      check(got[i] == u[i][Z-1:0], "R2 info pass", 32'(got[i]), u[i]);
    for (int j = 0; j < 16 - k; j++) begin
      logic [Z-1:0] e;
      e = '0;
      for (int c = 0; c < Z; c++) e[c] = syndrome(r, j, c, 1'b0);
      check(got[k + j] == e, "R4 R5 R7 parity", 32'(got[k + j]), 32'(e));
      s_ok = 1'b1;
      for (int c = 0; c < Z; c++) if (syndrome(r, j, c, got[k + j][c])) s_ok = 1'b0;
      check(s_ok, "R5 syndrome zero", 32'(!s_ok), 32'd0);
    end
    for (int b = 0; b < 16; b++)
      check(lastf[b] == (b == 15), "R9 last flag", 32'(lastf[b]), 32'(b == 15));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; rate_sel = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, "R1 reset out_valid", 32'(out_valid), 32'd0);
    check(in_ready == out_ready, "R1 reset ready", 32'(in_ready), 32'(out_ready));
    // Directed: all zero (parity zero), single bit, all ones, both rates
    for (int i = 0; i < 16; i++) u[i] = '0;
    send_cw(1'b0, 1'b0);
    send_cw(1'b1, 1'b0);
    u[3] = 32'h1 << (Z - 1);
    send_cw(1'b0, 1'b0);
    u[3] = '0; u[11] = 32'h4;
    send_cw(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) u[i] = '1;
    send_cw(1'b1, 1'b1);
    send_cw(1'b0, 1'b1);
    // R7: random back-to-back codewords with mixed rates under stalls
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < 16; i++) u[i] = $urandom;
      send_cw(1'($urandom % 2), n % 3 != 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule